// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory with Pin-Mode Decoding

This block is a synthesizable, clock-based model of a byte-wide one-time-programmable read-only memory as seen from its pins. Each clock edge samples the chip-select, the output-enable and the program-voltage flag. From them the model picks one of six modes: quiescent, fetch, output-off, burn, burn-blocked and signature. It then moves the memory and the data outputs one step on. Analog levels appear as flags. The high voltage on the output-enable pin is `vpp_hv`, and the high voltage on address bit 9 is `a9_hv`. Nanosecond access and float times appear as whole clock counts, set by parameters.

A burn can only clear bits. Each edge spent in burn mode turns the stored byte into the old value ANDed with `din`, so an unburnt cell reads 0xFF. In signature mode the array is bypassed and one of two fixed bytes is returned, 0x1E or 0x0D, chosen by address bit 0. The default depth is 1024 bytes so that the default build stays small. Setting `ADDR_W` to 16 gives the full 64K x 8 organization.

Top module: `otp_eprom_model`

## Requirements
- R1: The `mode` output is registered and reflects, one edge late, the inputs sampled at that edge. The codes are: 0 quiescent (`ce_n`=1, `vpp_hv`=0), 1 fetch (`ce_n`=0, `oe_n`=0, `vpp_hv`=0, `a9_hv`=0), 2 output-off (`ce_n`=0, `oe_n`=1, `vpp_hv`=0), 3 burn (`ce_n`=0, `vpp_hv`=1), 4 burn-blocked (`ce_n`=1, `vpp_hv`=1) and 5 signature (as fetch but `a9_hv`=1). Reset gives code 0 with `data_valid` and `dout_oe` low.
- R2: In fetch mode, once the delays of R3 are met, `dout` carries the byte stored at `addr`, and an unburnt byte reads 0xFF.
- R3: In fetch or signature mode, `data_valid` rises at the edge that completes three counts. These are at least `T_ACC` consecutive edges with the same `addr` and `a9_hv` (the edge that samples a change counts as the first), at least `T_CE` consecutive edges with `ce_n` low, and at least `T_OE` consecutive edges with `oe_n` low and `vpp_hv` low.
- R4: In fetch or signature mode, while any of the R3 counts is still short, both `data_valid` and `dout_oe` are low.
- R5: When an edge samples any mode other than fetch or signature, `data_valid` is low after that edge. `dout_oe` stays high with `dout` unchanged until the `T_DF`-th such consecutive edge, at which it falls.
- R6: Each edge sampled in burn mode sets the byte at `addr` to its old value AND `din`, so a burn can never turn a 0 bit back to 1.
- R7: Burn-blocked mode writes nothing: a byte held there with `din`=0x00 still reads 0xFF afterwards, and `data_valid` stays low during it.
- R8: Signature mode returns 0x1E when `addr[0]`=0 and 0x0D when `addr[0]`=1, whatever the other address bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; each edge is one time step |
| rst_n | input | 1 | Asynchronous active-low reset; clears the array to 0xFF |
| addr | input | ADDR_W | Byte address |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable, logic level |
| vpp_hv | input | 1 | Output-enable pin held at program voltage |
| a9_hv | input | 1 | Address bit 9 held at signature voltage |
| din | input | DATA_W | Byte to burn |
| dout | output | DATA_W | Data bus value |
| dout_oe | output | 1 | Data bus driven (low means high impedance) |
| data_valid | output | 1 | `dout` holds settled fetch or signature data |
| mode | output | 3 | Registered mode code of R1 |

## Verification
The hardest situation to reach is the one where several delay counts are still running when a mode begins, because the bench then has to know which count finishes last. The stimulus gets there by leaving one count saturated on purpose before the fetch starts. A burn that keeps `ce_n` low and the address fixed leaves only the output-enable count to run. Moving only the address leaves only the access count. Parking in quiescent mode with `oe_n` low leaves only the chip-select count. Each of these makes `data_valid` rise at a different edge that the bench can predict.

// File: rtl/otp_pkg.sv
package otp_pkg;

   typedef enum logic [2:0] {
      MD_QUIET   = 3'd0,
      MD_FETCH   = 3'd1,
      MD_OUTOFF  = 3'd2,
      MD_BURN    = 3'd3,
      MD_BLOCKED = 3'd4,
      MD_SIGN    = 3'd5
   } otp_mode_e;

   localparam logic [7:0] SIGN_MAKER = 8'h1E;
   localparam logic [7:0] SIGN_PART  = 8'h0D;

   function automatic logic mode_drives(input otp_mode_e m);
      return (m == MD_FETCH) || (m == MD_SIGN);
   endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
   import otp_pkg::*;
(
   input  logic      ce_n,
   input  logic      oe_n,
   input  logic      vpp_hv,
   input  logic      a9_hv,
   output otp_mode_e mode
);

   always_comb begin
      if (vpp_hv)
         mode = ce_n ? MD_BLOCKED : MD_BURN;
      else if (ce_n)
         mode = MD_QUIET;
      else if (oe_n)
         mode = MD_OUTOFF;
      else if (a9_hv)
         mode = MD_SIGN;
      else
         mode = MD_FETCH;
   end

endmodule

// File: rtl/otp_array.sv
module otp_array #(
   parameter int ADDR_W     = 10,
   parameter int DATA_W     = 8,
   parameter bit CLEAR_ONLY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];
   logic [DATA_W-1:0] merged;

   assign rdata = cells[addr];

   generate
      if (CLEAR_ONLY) begin : g_fuse
         assign merged = rdata & wdata;
      end else begin : g_plain
         assign merged = wdata;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            cells[i] <= '1;
      end else if (wr_en) begin
         cells[addr] <= merged;
      end
   end

endmodule

// File: rtl/otp_timing.sv
module otp_timing #(
   parameter int ADDR_W = 10,
   parameter int T_ACC  = 9,
   parameter int T_CE   = 9,
   parameter int T_OE   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              a9_hv,
   input  logic              ce_n,
   input  logic              oe_act,
   output logic              ready
);

   localparam int T_MAX01 = (T_ACC > T_CE) ? T_ACC : T_CE;
   localparam int T_MAX   = (T_MAX01 > T_OE) ? T_MAX01 : T_OE;
   localparam int CNT_W   = $clog2(T_MAX + 1);
   localparam int N_RUN   = 3;

   logic [ADDR_W-1:0] addr_q;
   logic              a9_q;
   logic              moved;
   logic [N_RUN-1:0]  act;
   logic [N_RUN-1:0]  restart;
   logic [N_RUN-1:0]  met;

   assign moved   = (addr != addr_q) || (a9_hv != a9_q);
   assign act     = {oe_act, ~ce_n, 1'b1};
   assign restart = {1'b0, 1'b0, moved};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         a9_q   <= 1'b0;
      end else begin
         addr_q <= addr;
         a9_q   <= a9_hv;
      end
   end

   generate
      for (genvar i = 0; i < N_RUN; i++) begin : g_run
         localparam int THR = (i == 0) ? T_ACC : ((i == 1) ? T_CE : T_OE);
         logic [CNT_W-1:0] run_q;
         logic [CNT_W-1:0] run_d;

         always_comb begin
            if (!act[i])
               run_d = '0;
            else if (restart[i])
               run_d = CNT_W'(1);
            else if (run_q == CNT_W'(T_MAX))
               run_d = run_q;
            else
               run_d = run_q + CNT_W'(1);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               run_q <= '0;
            else
               run_q <= run_d;
         end

         assign met[i] = (run_d >= CNT_W'(THR));
      end
   endgenerate

   assign ready = &met;

endmodule

// File: rtl/otp_out_stage.sv
module otp_out_stage
   import otp_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int T_DF   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  otp_mode_e         mode_in,
   input  logic              ready,
   input  logic [DATA_W-1:0] rbyte,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe,
   output logic              data_valid,
   output logic [2:0]        mode
);

   localparam int HOLD_W = $clog2(T_DF + 1);

   logic              drive_mode;
   logic              valid_d;
   logic [HOLD_W-1:0] hold_q;

   assign drive_mode = mode_drives(mode_in);
   assign valid_d    = drive_mode && ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout       <= '0;
         dout_oe    <= 1'b0;
         data_valid <= 1'b0;
         hold_q     <= '0;
         mode       <= MD_QUIET;
      end else begin
         mode       <= mode_in;
         data_valid <= valid_d;
         if (valid_d) begin
            dout    <= rbyte;
            dout_oe <= 1'b1;
            hold_q  <= HOLD_W'(T_DF);
         end else if (drive_mode) begin
            dout_oe <= 1'b0;
         end else if (dout_oe) begin
            if (hold_q <= HOLD_W'(1))
               dout_oe <= 1'b0;
            else
               hold_q <= hold_q - HOLD_W'(1);
         end
      end
   end

endmodule

// File: rtl/otp_eprom_model.sv
module otp_eprom_model
   import otp_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int DATA_W     = 8,
   parameter int T_ACC      = 9,
   parameter int T_CE       = 9,
   parameter int T_OE       = 5,
   parameter int T_DF       = 4,
   parameter bit CLEAR_ONLY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              vpp_hv,
   input  logic              a9_hv,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe,
   output logic              data_valid,
   output logic [2:0]        mode
);

   generate
      if (T_ACC < 1 || T_CE < 1 || T_OE < 1 || T_DF < 1) begin : g_bad_delay
         $error("otp_eprom_model: every delay must be at least one cycle");
      end
      if (DATA_W != 8) begin : g_bad_width
         $error("otp_eprom_model: signature bytes need DATA_W of 8");
      end
      if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr
         $error("otp_eprom_model: ADDR_W must lie in 2..16");
      end
   endgenerate

   otp_mode_e         cur_mode;
   logic              ready;
   logic [DATA_W-1:0] arr_byte;
   logic [DATA_W-1:0] out_byte;

   otp_mode_decode u_decode (
      .ce_n   (ce_n),
      .oe_n   (oe_n),
      .vpp_hv (vpp_hv),
      .a9_hv  (a9_hv),
      .mode   (cur_mode)
   );

   otp_array #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .CLEAR_ONLY (CLEAR_ONLY)
   ) u_array (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (cur_mode == MD_BURN),
      .addr  (addr),
      .wdata (din),
      .rdata (arr_byte)
   );

   otp_timing #(
      .ADDR_W (ADDR_W),
      .T_ACC  (T_ACC),
      .T_CE   (T_CE),
      .T_OE   (T_OE)
   ) u_timing (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (addr),
      .a9_hv  (a9_hv),
      .ce_n   (ce_n),
      .oe_act (~oe_n & ~vpp_hv),
      .ready  (ready)
   );

   assign out_byte = (cur_mode == MD_SIGN) ? (addr[0] ? SIGN_PART : SIGN_MAKER)
                                           : arr_byte;

   otp_out_stage #(
      .DATA_W (DATA_W),
      .T_DF   (T_DF)
   ) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_in    (cur_mode),
      .ready      (ready),
      .rbyte      (out_byte),
      .dout       (dout),
      .dout_oe    (dout_oe),
      .data_valid (data_valid),
      .mode       (mode)
   );

endmodule

// File: rtl/otp_eprom_chk.sv
module otp_eprom_chk
   import otp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              vpp_hv,
   input logic [DATA_W-1:0] dout,
   input logic              dout_oe,
   input logic              data_valid,
   input logic [2:0]        mode
);

   assert_valid_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> dout_oe);

   assert_ce_high_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> !data_valid);

   assert_drive_starts_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_oe) |-> data_valid);

   assert_float_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_oe && !data_valid) |-> $stable(dout));

   assert_sign_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (data_valid && mode == 3'd5) |-> (dout == SIGN_MAKER || dout == SIGN_PART));

   assert_burn_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && vpp_hv) |=> (mode == 3'd3 && !data_valid));

   assert_blocked_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n && vpp_hv) |=> (mode == 3'd4 && !data_valid));

endmodule

bind otp_eprom_model otp_eprom_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ce_n       (ce_n),
   .vpp_hv     (vpp_hv),
   .dout       (dout),
   .dout_oe    (dout_oe),
   .data_valid (data_valid),
   .mode       (mode)
);

// File: tb/test_otp_eprom_model.sv
module test_otp_eprom_model;

   localparam int AW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          ce_n = 1'b1;
   logic          oe_n = 1'b1;
   logic          vpp_hv = 1'b0;
   logic          a9_hv = 1'b0;
   logic [7:0]    din = '0;
   logic [7:0]    dout;
   logic          dout_oe;
   logic          data_valid;
   logic [2:0]    mode;

   always #2 clk = ~clk;

   otp_eprom_model #(
      .ADDR_W (AW), .DATA_W (8),
      .T_ACC (3), .T_CE (3), .T_OE (2), .T_DF (2), .CLEAR_ONLY (1'b1)
   ) i_otp_eprom_model (
      .clk (clk), .rst_n (rst_n), .addr (addr), .ce_n (ce_n), .oe_n (oe_n),
      .vpp_hv (vpp_hv), .a9_hv (a9_hv), .din (din), .dout (dout),
      .dout_oe (dout_oe), .data_valid (data_valid), .mode (mode)
   );

   typedef struct {
      int         at;
      string      tag;
      logic [3:0] what;   // bit0 valid, bit1 drive, bit2 data, bit3 mode
      logic       dv;
      logic       oe;
      logic [7:0] data;
      logic [2:0] md;
   } item_t;

   item_t q[$];
   int    cyc = 0;
   int    n_vec = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   always @(posedge clk) cyc++;

   always @(negedge clk) begin
      while (q.size() > 0 && q[0].at == cyc) begin
         item_t it;
         it = q.pop_front();
         n_vec++;
         if (it.what[0] && data_valid !== it.dv) begin
            n_fail++;
            $display("FAIL %s data_valid got %b exp %b (cycle %0d)", it.tag, data_valid, it.dv, cyc);
         end
         if (it.what[1] && dout_oe !== it.oe) begin
            n_fail++;
            $display("FAIL %s dout_oe got %b exp %b (cycle %0d)", it.tag, dout_oe, it.oe, cyc);
         end
         if (it.what[2] && dout !== it.data) begin
            n_fail++;
            $display("FAIL %s dout got %h exp %h (cycle %0d)", it.tag, dout, it.data, cyc);
         end
         if (it.what[3] && mode !== it.md) begin
            n_fail++;
            $display("FAIL %s mode got %0d exp %0d (cycle %0d)", it.tag, mode, it.md, cyc);
         end
      end
   end

   task automatic expect_at(int k, string tag, logic [3:0] what, logic dv, logic oe,
                            logic [7:0] data, logic [2:0] md);
      item_t it;
      it.at = cyc + k; it.tag = tag; it.what = what;
      it.dv = dv; it.oe = oe; it.data = data; it.md = md;
      q.push_back(it);
   endtask

   task automatic drive(logic c, logic o, logic v, logic a9, logic [AW-1:0] a, logic [7:0] d);
      ce_n = c; oe_n = o; vpp_hv = v; a9_hv = a9; addr = a; din = d;
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      expect_at(1, "R1 reset", 4'b1011, 0, 0, 8'h00, 3'd0);
      step(2);
      // fetch of an unburnt byte: all three counts start together
      drive(0, 0, 0, 0, 10'd5, 8'h00);
      expect_at(1, "R4 fetch wait", 4'b1011, 0, 0, 8'h00, 3'd1);
      expect_at(2, "R3 fetch early", 4'b0011, 0, 0, 8'h00, 3'd0);
      expect_at(3, "R2 unburnt", 4'b1111, 1, 1, 8'hFF, 3'd1);
      step(4);
      // two burns on one byte
      drive(0, 1, 1, 0, 10'd5, 8'hA5);
      expect_at(1, "R6 burn mode", 4'b1001, 0, 0, 8'h00, 3'd3);
      step(1);
      drive(0, 1, 1, 0, 10'd5, 8'h3C);
      step(1);
      // only the output-enable count is short now
      drive(0, 0, 0, 0, 10'd5, 8'h00);
      expect_at(1, "R3 oe count", 4'b0011, 0, 0, 8'h00, 3'd0);
      expect_at(2, "R6 and-merge", 4'b0111, 1, 1, 8'h24, 3'd0);
      step(3);
      // output-off: float hold
      drive(0, 1, 0, 0, 10'd5, 8'h00);
      expect_at(1, "R5 float hold", 4'b1111, 0, 1, 8'h24, 3'd2);
      expect_at(2, "R5 float end", 4'b0011, 0, 0, 8'h00, 3'd0);
      step(3);
      drive(0, 0, 0, 0, 10'd5, 8'h00);
      expect_at(2, "R3 oe again", 4'b0101, 1, 0, 8'h24, 3'd0);
      step(3);
      // only the access count is short
      drive(0, 0, 0, 0, 10'd6, 8'h00);
      expect_at(1, "R4 addr move", 4'b0011, 0, 0, 8'h00, 3'd0);
      expect_at(2, "R3 addr early", 4'b0001, 0, 0, 8'h00, 3'd0);
      expect_at(3, "R2 addr 6", 4'b0111, 1, 1, 8'hFF, 3'd0);
      step(4);
      // quiescent, then only the chip-select count is short
      drive(1, 0, 0, 0, 10'd6, 8'h00);
      expect_at(1, "R5 quiet hold", 4'b1111, 0, 1, 8'hFF, 3'd0);
      expect_at(2, "R5 quiet float", 4'b0010, 0, 0, 8'h00, 3'd0);
      step(3);
      drive(0, 0, 0, 0, 10'd6, 8'h00);
      expect_at(2, "R3 ce early", 4'b0011, 0, 0, 8'h00, 3'd0);
      expect_at(3, "R3 ce done", 4'b0101, 1, 0, 8'hFF, 3'd0);
      step(4);
      // signature bytes
      drive(0, 0, 0, 1, 10'h000, 8'h00);
      expect_at(1, "R1 sign mode", 4'b1001, 0, 0, 8'h00, 3'd5);
      expect_at(3, "R8 maker", 4'b0101, 1, 0, 8'h1E, 3'd0);
      step(4);
      drive(0, 0, 0, 1, 10'h001, 8'h00);
      expect_at(2, "R8 wait", 4'b0001, 0, 0, 8'h00, 3'd0);
      expect_at(3, "R8 part", 4'b0101, 1, 0, 8'h0D, 3'd0);
      step(4);
      drive(0, 0, 0, 1, 10'h3FE, 8'h00);
      expect_at(3, "R8 high bits maker", 4'b0101, 1, 0, 8'h1E, 3'd0);
      step(4);
      drive(0, 0, 0, 1, 10'h201, 8'h00);
      expect_at(3, "R8 high bits part", 4'b0101, 1, 0, 8'h0D, 3'd0);
      step(4);
      // burn-blocked writes nothing
      drive(1, 1, 1, 0, 10'd7, 8'h00);
      expect_at(1, "R7 blocked mode", 4'b1001, 0, 0, 8'h00, 3'd4);
      step(3);
      drive(0, 0, 0, 0, 10'd7, 8'h00);
      expect_at(3, "R7 no write", 4'b0101, 1, 0, 8'hFF, 3'd0);
      step(4);
      // top address burnt to zero, bottom address untouched
      drive(0, 1, 1, 0, 10'h3FF, 8'h00);
      expect_at(1, "R1 burn code", 4'b1000, 0, 0, 8'h00, 3'd3);
      step(2);
      drive(0, 0, 0, 0, 10'h3FF, 8'h00);
      expect_at(2, "R6 top byte", 4'b0101, 1, 0, 8'h00, 3'd0);
      step(3);
      drive(0, 0, 0, 0, 10'h000, 8'h00);
      expect_at(3, "R2 bottom byte", 4'b0101, 1, 0, 8'hFF, 3'd0);
      step(4);
      // burning ones cannot restore cleared bits
      drive(0, 1, 1, 0, 10'd5, 8'hFF);
      step(1);
      drive(0, 0, 0, 0, 10'd5, 8'h00);
      expect_at(2, "R6 no set", 4'b0101, 1, 0, 8'h24, 3'd0);
      step(3);
      drive(1, 1, 0, 0, 10'd5, 8'h00);
      step(4);
      if (q.size() != 0) begin
         n_fail++;
         $display("FAIL R1 pending checks got %0d exp 0", q.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog got timeout exp completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule